// File: doc/BRIEF.md
# Four-Channel Prioritized Memory Copy Engine

This block moves data between two address ranges without processor involvement. It has four independent channels. Each channel holds a source address, a destination address, a unit count and a 16-bit control word, all programmed over a simple register write port. Once a channel is armed and triggered, the block copies one 16-bit or 32-bit unit per service step. Each step is a bus read from the working source address followed by a bus write of the same data to the working destination address. Every step uses a request/ready handshake on a single bus master port.

A channel starts in one of three ways: immediately when it is enabled, on a vertical-blank pulse, or on a horizontal-blank pulse. When several channels are pending, a fixed priority decides which one is served. Priority is decided again before every unit, so a more urgent channel can step in between the units of a less urgent one. When a run finishes there are two outcomes. A one-shot channel disables itself and clears part of its control word. A repeating channel reloads its count, and optionally its destination, and waits for the next trigger. A channel with its interrupt bit set raises a one-cycle pulse when a run completes.

The engine is a four-state machine:
- IDLE waits for a pending channel. On the *grant* transition it latches the winning channel and moves to READ.
- READ holds a read request. On the *read-accepted* transition it captures the data and moves to WRITE.
- WRITE holds a write request. On the *write-accepted* transition it moves to RETIRE.
- RETIRE tells the served channel that its unit is done. It then takes the *return* transition back to IDLE.

Top module: `dma4_ctrl`

## Requirements
- R1: Register select codes are 0 source, 1 destination, 2 count, 3 control. A write to the source or destination register stores the value with bit 0 forced to zero, and the readback returns that value.
- R2: After reset every control register reads 0 and every count register reads 0x10000. Writing a count of 0 stores 0x4000 on channels 0 to 2 and 0x10000 on channel 3.
- R3: The address mode fields are bits 8:7 (source) and bits 6:5 (destination): 0 increments, 1 decrements, 2 holds, 3 increments (reload on repeat). Control bit 10 selects 32-bit units, which step by 4 bytes; 16-bit units step by 2 bytes.
- R4: For 32-bit units, the working addresses start at the programmed addresses aligned down to a multiple of 4. The programmed registers themselves keep their values.
- R5: Only a 0-to-1 change of control bit 15 copies source, destination and count into the working registers and starts a new run. Rewriting the control word while the channel is already enabled changes neither the working addresses nor the progress of the run.
- R6: Control bits 13:12 select the trigger: 0 starts as soon as the channel is enabled, 1 waits for a vertical-blank pulse, 2 waits for a horizontal-blank pulse. A pulse has no effect on channels with another trigger mode.
- R7: When several channels are pending, the lowest-numbered one is served first. The choice is made again before every unit.
- R8: Each unit is a read from the working source followed by a write of the same data to the working destination. A request holds its address and direction until ready is seen. The working registers advance only after the write is accepted.
- R9: When a run without repeat (bit 9 clear) finishes, the channel stops and its control word becomes its old value ANDed with 0x7FE0.
- R10: When a run with repeat (bit 9 set) finishes, the channel stays enabled and reloads its count. It reloads its destination only in destination mode 3. It waits for the next blank pulse of its mode, and the source keeps advancing.
- R11: When a run finishes with interrupt enable (bit 14) set, that channel's interrupt output pulses for exactly one cycle. With bit 14 clear, no pulse is raised.
- R12: The sequential flag is 0 for both bus accesses of the first unit of a run and 1 for every later unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_ch | input | 2 | Channel addressed by the write |
| reg_sel | input | 2 | Register select for the write (0 src, 1 dst, 2 count, 3 control) |
| reg_wdata | input | 32 | Write data |
| rd_ch | input | 2 | Channel addressed by the readback |
| rd_sel | input | 2 | Register select for the readback |
| rd_data | output | 32 | Readback value (combinational) |
| hblank | input | 1 | Horizontal-blank trigger pulse |
| vblank | input | 1 | Vertical-blank trigger pulse |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_wide | output | 1 | 1 = 32-bit unit, 0 = 16-bit unit |
| bus_seq | output | 1 | 0 on the first unit of a run, 1 on later units |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ready during a read |
| bus_ready | input | 1 | Completes the current request |
| irq_pulse | output | 4 | Per-channel completion pulse |

## Verification
The copy path is tried with four patterns:
- 16-bit increment/decrement with a stalling bus, which separates the address-step sign and the handshake hold.
- 32-bit with a held source and odd programmed addresses, which exposes the alignment and the 4-byte step.
- Two blank-triggered channels pending at once, where the order of their units shows the priority.
- A repeating horizontal-blank channel run twice, with a control rewrite and a stray vertical-blank pulse in between. This separates destination reload, source continuation, re-arming and trigger filtering.

Control and count readback after completion and after zero-count writes covers the clear mask and the per-channel maximum.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

    localparam int unsigned ADDR_W = 32;

    typedef enum logic [1:0] {
        REG_SRC = 2'd0,
        REG_DST = 2'd1,
        REG_CNT = 2'd2,
        REG_CTL = 2'd3
    } dma_reg_e;

    typedef enum logic [1:0] {
        TRG_NOW    = 2'd0,
        TRG_VBLANK = 2'd1,
        TRG_HBLANK = 2'd2,
        TRG_NONE   = 2'd3
    } dma_trig_e;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_READ,
        ENG_WRITE,
        ENG_RETIRE
    } eng_state_e;

    // control word, msb first
    typedef struct packed {
        logic       en;
        logic       irq_en;
        logic [1:0] trig;
        logic       spare;
        logic       wide;
        logic       rpt;
        logic [1:0] src_mode;
        logic [1:0] dst_mode;
        logic [4:0] low;
    } dma_ctl_t;

    localparam logic [15:0] CTL_DONE_KEEP = 16'h7FE0;
    localparam logic [1:0]  MODE_RELOAD   = 2'd3;

    function automatic logic [ADDR_W-1:0] step_of(logic [1:0] mode, logic wide);
        logic [ADDR_W-1:0] bytes;
        bytes = wide ? ADDR_W'(4) : ADDR_W'(2);
        case (mode)
            2'd1:    step_of = ADDR_W'(0) - bytes;
            2'd2:    step_of = ADDR_W'(0);
            default: step_of = bytes;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] align_of(logic [ADDR_W-1:0] a, logic wide);
        align_of = wide ? {a[ADDR_W-1:2], 2'b00} : a;
    endfunction

endpackage

// File: rtl/dma4_channel.sv
module dma4_channel
    import dma4_pkg::*;
#(
    parameter int unsigned CNT_W   = 17,
    parameter logic [CNT_W-1:0] CNT_MAX = CNT_W'(16384),
    parameter logic [CNT_W-1:0] CNT_RST = CNT_W'(65536)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  dma_reg_e          wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              hblank,
    input  logic              vblank,
    input  logic              unit_done,
    output logic              pending,
    output logic              first_unit,
    output logic [ADDR_W-1:0] work_src,
    output logic [ADDR_W-1:0] work_dst,
    output logic              wide,
    output logic [15:0]       ctl_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic              irq
);

    dma_ctl_t          ctl_r;
    logic [ADDR_W-1:0] src_r, dst_r, wsrc, wdst;
    logic [CNT_W-1:0]  cnt_r, wcnt, cnt_wr_val;
    logic              pend, first_r;
    logic              trig_hit;
    logic              last_unit;

    assign cnt_wr_val = (wr_data[15:0] == 16'd0) ? CNT_MAX : CNT_W'(wr_data[15:0]);
    assign trig_hit   = ctl_r.en &&
                        ((vblank && ctl_r.trig == TRG_VBLANK) ||
                         (hblank && ctl_r.trig == TRG_HBLANK));
    assign last_unit  = (wcnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_r   <= '0;
            src_r   <= '0;
            dst_r   <= '0;
            cnt_r   <= CNT_RST;
            wsrc    <= '0;
            wdst    <= '0;
            wcnt    <= '0;
            pend    <= 1'b0;
            first_r <= 1'b0;
            irq     <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (unit_done && ctl_r.en) begin
                wsrc    <= wsrc + step_of(ctl_r.src_mode, ctl_r.wide);
                wdst    <= wdst + step_of(ctl_r.dst_mode, ctl_r.wide);
                wcnt    <= wcnt - CNT_W'(1);
                first_r <= 1'b0;
                if (last_unit) begin
                    irq  <= ctl_r.irq_en;
                    pend <= 1'b0;
                    if (ctl_r.rpt) begin
                        wcnt    <= cnt_r;
                        first_r <= 1'b1;
                        if (ctl_r.dst_mode == MODE_RELOAD) begin
                            wdst <= align_of(dst_r, ctl_r.wide);
                        end
                    end else begin
                        ctl_r <= dma_ctl_t'(16'(ctl_r) & CTL_DONE_KEEP);
                    end
                end
            end
            if (trig_hit) begin
                pend <= 1'b1;
            end
            if (wr_en) begin
                unique case (wr_sel)
                    REG_SRC: src_r <= {wr_data[ADDR_W-1:1], 1'b0};
                    REG_DST: dst_r <= {wr_data[ADDR_W-1:1], 1'b0};
                    REG_CNT: cnt_r <= cnt_wr_val;
                    REG_CTL: begin
                        ctl_r <= dma_ctl_t'(wr_data[15:0]);
                        if (!ctl_r.en && wr_data[15]) begin
                            wsrc    <= align_of(src_r, wr_data[10]);
                            wdst    <= align_of(dst_r, wr_data[10]);
                            wcnt    <= cnt_r;
                            first_r <= 1'b1;
                            pend    <= (wr_data[13:12] == TRG_NOW);
                        end
                        if (!wr_data[15]) begin
                            pend <= 1'b0;
                        end
                    end
                endcase
            end
        end
    end

    assign pending    = pend && ctl_r.en;
    assign first_unit = first_r;
    assign work_src   = wsrc;
    assign work_dst   = wdst;
    assign wide       = ctl_r.wide;
    assign ctl_q      = 16'(ctl_r);
    assign cnt_q      = cnt_r;
    assign src_q      = src_r;
    assign dst_q      = dst_r;

endmodule

// File: rtl/dma4_arbiter.sv
module dma4_arbiter #(
    parameter int unsigned NCH   = 4,
    localparam int unsigned IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0]   req,
    output logic [IDX_W-1:0] grant_idx,
    output logic             grant_any
);

    always_comb begin
        grant_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant_idx = IDX_W'(i);
            end
        end
    end

    assign grant_any = |req;

endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
    import dma4_pkg::*;
#(
    parameter int unsigned NCH   = 4,
    localparam int unsigned IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant_any,
    input  logic [IDX_W-1:0]  grant_idx,
    input  logic              bus_ready,
    input  logic [ADDR_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] data_q,
    output logic [IDX_W-1:0]  sel_idx,
    output logic [NCH-1:0]    done_vec
);

    eng_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ENG_IDLE:   if (grant_any) nxt = ENG_READ;
            ENG_READ:   if (bus_ready) nxt = ENG_WRITE;
            ENG_WRITE:  if (bus_ready) nxt = ENG_RETIRE;
            ENG_RETIRE: nxt = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ENG_IDLE;
            sel_idx <= '0;
            data_q  <= '0;
        end else begin
            state <= nxt;
            if (state == ENG_IDLE && grant_any) begin
                sel_idx <= grant_idx;
            end
            if (state == ENG_READ && bus_ready) begin
                data_q <= bus_rdata;
            end
        end
    end

    always_comb begin
        bus_req  = 1'b0;
        bus_we   = 1'b0;
        done_vec = '0;
        unique case (state)
            ENG_IDLE:   ;
            ENG_READ:   bus_req = 1'b1;
            ENG_WRITE: begin
                bus_req = 1'b1;
                bus_we  = 1'b1;
            end
            ENG_RETIRE: done_vec = NCH'(1) << sel_idx;
        endcase
    end

endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
    import dma4_pkg::*;
#(
    parameter int unsigned NCH       = 4,
    parameter int unsigned CNT_W     = 17,
    parameter int unsigned SMALL_MAX = 16384,
    parameter int unsigned BIG_MAX   = 65536,
    localparam int unsigned IDX_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_ch,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic [IDX_W-1:0]  rd_ch,
    input  logic [1:0]        rd_sel,
    output logic [ADDR_W-1:0] rd_data,
    input  logic              hblank,
    input  logic              vblank,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_wide,
    output logic              bus_seq,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [ADDR_W-1:0] bus_wdata,
    input  logic [ADDR_W-1:0] bus_rdata,
    input  logic              bus_ready,
    output logic [NCH-1:0]    irq_pulse
);

    logic [NCH-1:0]    pend_v, first_v, wide_v, done_v;
    logic [ADDR_W-1:0] wsrc_a [NCH];
    logic [ADDR_W-1:0] wdst_a [NCH];
    logic [ADDR_W-1:0] src_a  [NCH];
    logic [ADDR_W-1:0] dst_a  [NCH];
    logic [CNT_W-1:0]  cnt_a  [NCH];
    logic [15:0]       ctl_a  [NCH];
    logic [IDX_W-1:0]  grant_idx, sel_idx;
    logic              grant_any;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dma4_channel #(
            .CNT_W   (CNT_W),
            .CNT_MAX ((i == NCH - 1) ? CNT_W'(BIG_MAX) : CNT_W'(SMALL_MAX)),
            .CNT_RST (CNT_W'(BIG_MAX))
        ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (reg_wr && reg_ch == IDX_W'(i)),
            .wr_sel     (dma_reg_e'(reg_sel)),
            .wr_data    (reg_wdata),
            .hblank     (hblank),
            .vblank     (vblank),
            .unit_done  (done_v[i]),
            .pending    (pend_v[i]),
            .first_unit (first_v[i]),
            .work_src   (wsrc_a[i]),
            .work_dst   (wdst_a[i]),
            .wide       (wide_v[i]),
            .ctl_q      (ctl_a[i]),
            .cnt_q      (cnt_a[i]),
            .src_q      (src_a[i]),
            .dst_q      (dst_a[i]),
            .irq        (irq_pulse[i])
        );
    end

    dma4_arbiter #(.NCH(NCH)) u_arb (
        .req       (pend_v),
        .grant_idx (grant_idx),
        .grant_any (grant_any)
    );

    dma4_engine #(.NCH(NCH)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant_any (grant_any),
        .grant_idx (grant_idx),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .data_q    (bus_wdata),
        .sel_idx   (sel_idx),
        .done_vec  (done_v)
    );

    assign bus_addr = bus_we ? wdst_a[sel_idx] : wsrc_a[sel_idx];
    assign bus_wide = wide_v[sel_idx];
    assign bus_seq  = !first_v[sel_idx];

    always_comb begin
        unique case (dma_reg_e'(rd_sel))
            REG_SRC: rd_data = src_a[rd_ch];
            REG_DST: rd_data = dst_a[rd_ch];
            REG_CNT: rd_data = ADDR_W'(cnt_a[rd_ch]);
            REG_CTL: rd_data = ADDR_W'(ctl_a[rd_ch]);
        endcase
    end

endmodule

// File: rtl/dma4_checker.sv
module dma4_checker #(
    parameter int unsigned NCH = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_we,
    input logic          bus_ready,
    input logic [31:0]   bus_addr,
    input logic [31:0]   bus_wdata,
    input logic [31:0]   bus_rdata,
    input logic [NCH-1:0] irq_pulse
);

    logic [31:0] rd_cap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cap <= '0;
        end else if (bus_req && !bus_we && bus_ready) begin
            rd_cap <= bus_rdata;
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_we));

    // R8
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we && bus_ready |=> bus_req && bus_we);

    // R8
    write_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we |-> bus_wdata == rd_cap);

    // R11
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_pulse));

    // R11
    irq_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse != '0) |=> ((irq_pulse & $past(irq_pulse)) == '0));

endmodule

bind dma4_ctrl dma4_checker #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_ready (bus_ready),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_pulse (irq_pulse)
);

// File: tb/test_dma4_ctrl.sv
`timescale 1ns/100ps
module test_dma4_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_ch = '0, reg_sel = '0, rd_ch = '0, rd_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rd_data;
    logic        hblank = 1'b0, vblank = 1'b0;
    logic        bus_req, bus_we, bus_wide, bus_seq;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic        bus_ready = 1'b1;
    logic [3:0]  irq_pulse;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    logic stall_en = 1'b0;
    logic tog = 1'b1;

    logic        lg_we   [64];
    logic [31:0] lg_addr [64];
    logic [31:0] lg_data [64];
    logic        lg_seq  [64];
    logic        lg_wide [64];
    int          lg_n = 0;
    int          irq_n [4];

    always #2.5 clk = ~clk;

    assign bus_rdata = {bus_addr[15:0], ~bus_addr[15:0]};

    dma4_ctrl i_dma4_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ch(reg_ch), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data),
        .hblank(hblank), .vblank(vblank), .bus_req(bus_req), .bus_we(bus_we),
        .bus_wide(bus_wide), .bus_seq(bus_seq), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .irq_pulse(irq_pulse)
    );

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(negedge clk) begin
        if (stall_en) tog = !tog;
        else tog = 1'b1;
        bus_ready = tog;
        if (rst_n && bus_req && bus_ready && lg_n < 64) begin
            lg_we[lg_n]   = bus_we;
            lg_addr[lg_n] = bus_addr;
            lg_data[lg_n] = bus_we ? bus_wdata : bus_rdata;
            lg_seq[lg_n]  = bus_seq;
            lg_wide[lg_n] = bus_wide;
            lg_n++;
        end
        for (int i = 0; i < 4; i++) irq_n[i] += int'(irq_pulse[i]);
        cyc++;
        if (cyc > 150000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual cyc=%0d expected < 150000", cyc);
            finish_run();
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        lg_n = 0;
        for (int i = 0; i < 4; i++) irq_n[i] = 0;
    endtask

    task automatic wr(input int ch, input int sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_ch = 2'(ch); reg_sel = 2'(sel); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int ch, input int sel, output logic [31:0] d);
        rd_ch = 2'(ch); rd_sel = 2'(sel);
        #1;
        d = rd_data;
    endtask

    task automatic pulse(input logic is_h);
        @(negedge clk);
        if (is_h) hblank = 1'b1; else vblank = 1'b1;
        @(negedge clk);
        hblank = 1'b0; vblank = 1'b0;
    endtask

    task automatic wait_log(input int n);
        for (int k = 0; k < 2000 && lg_n < n; k++) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    // check one unit: entry 2u is the read, 2u+1 the write
    task automatic check_unit(string req, int u, logic [31:0] s, logic [31:0] d, logic seq, logic wide);
        check(req, {31'd0, lg_we[2*u]}, 32'd0);
        check(req, lg_addr[2*u], s);
        check(req, {31'd0, lg_we[2*u+1]}, 32'd1);
        check(req, lg_addr[2*u+1], d);
        check({req, " R8"}, lg_data[2*u+1], {s[15:0], ~s[15:0]});
        check({req, " R12"}, {31'd0, lg_seq[2*u]}, {31'd0, seq});
        check({req, " R12"}, {31'd0, lg_seq[2*u+1]}, {31'd0, seq});
        check(req, {31'd0, lg_wide[2*u]}, {31'd0, wide});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int c = 0; c < 4; c++) begin
            rd(c, 3, v); check("R2 reset ctl", v, 32'h0);
            rd(c, 2, v); check("R2 reset cnt", v, 32'h10000);
        end
        check("R8 idle bus", {31'd0, bus_req}, 32'd0);
    endtask

    task automatic t_zero_count();
        logic [31:0] v;
        wr(0, 2, 32'h0); rd(0, 2, v); check("R2 zero cnt ch0", v, 32'h4000);
        wr(2, 2, 32'h0); rd(2, 2, v); check("R2 zero cnt ch2", v, 32'h4000);
        wr(3, 2, 32'h0); rd(3, 2, v); check("R2 zero cnt ch3", v, 32'h10000);
        wr(1, 2, 32'h5); rd(1, 2, v); check("R2 plain cnt", v, 32'h5);
    endtask

    task automatic t_imm16_stall();
        logic [31:0] v;
        clear_log();
        stall_en = 1'b1;
        wr(0, 0, 32'h0000_0101); rd(0, 0, v); check("R1 src bit0", v, 32'h100);
        wr(0, 1, 32'h0000_0201); rd(0, 1, v); check("R1 dst bit0", v, 32'h200);
        wr(0, 2, 32'd3);
        wr(0, 3, 32'h0000_C03F);
        wait_log(6);
        stall_en = 1'b0;
        check("R3 unit count", 32'(lg_n), 32'd6);
        check_unit("R3 R6 imm u0", 0, 32'h100, 32'h200, 1'b0, 1'b0);
        check_unit("R3 imm u1",    1, 32'h102, 32'h1FE, 1'b1, 1'b0);
        check_unit("R3 imm u2",    2, 32'h104, 32'h1FC, 1'b1, 1'b0);
        rd(0, 3, v); check("R9 ctl cleared", v, 32'h4020);
        check("R11 irq once", 32'(irq_n[0]), 32'd1);
    endtask

    task automatic t_wide_fixed();
        logic [31:0] v;
        clear_log();
        wr(3, 0, 32'h0000_1002);
        wr(3, 1, 32'h0000_2006);
        wr(3, 2, 32'd2);
        wr(3, 3, 32'h0000_8500);
        wait_log(4);
        check("R4 unit count", 32'(lg_n), 32'd4);
        check_unit("R4 R3 wide u0", 0, 32'h1000, 32'h2004, 1'b0, 1'b1);
        check_unit("R3 wide u1",    1, 32'h1000, 32'h2008, 1'b1, 1'b1);
        rd(3, 0, v); check("R4 src reg kept", v, 32'h1002);
        rd(3, 3, v); check("R9 ctl cleared", v, 32'h0500);
        check("R11 no irq", 32'(irq_n[3]), 32'd0);
    endtask

    task automatic t_priority();
        clear_log();
        wr(2, 0, 32'h3000); wr(2, 1, 32'h3100); wr(2, 2, 32'd2); wr(2, 3, 32'h9000);
        wr(1, 0, 32'h4000); wr(1, 1, 32'h4100); wr(1, 2, 32'd2); wr(1, 3, 32'h9000);
        repeat (8) @(negedge clk);
        check("R6 vblank waits", 32'(lg_n), 32'd0);
        pulse(1'b0);
        wait_log(8);
        check("R7 unit count", 32'(lg_n), 32'd8);
        check("R7 first served", lg_addr[0], 32'h4000);
        check("R7 second", lg_addr[2], 32'h4002);
        check("R7 third", lg_addr[4], 32'h3000);
        check("R7 fourth", lg_addr[6], 32'h3002);
    endtask

    task automatic t_repeat_reload();
        logic [31:0] v;
        clear_log();
        wr(0, 0, 32'h500); wr(0, 1, 32'h600); wr(0, 2, 32'd2);
        wr(0, 3, 32'h0000_A260);
        repeat (8) @(negedge clk);
        check("R6 hblank waits", 32'(lg_n), 32'd0);
        pulse(1'b0);
        repeat (8) @(negedge clk);
        check("R6 vblank ignored", 32'(lg_n), 32'd0);
        pulse(1'b1);
        wait_log(4);
        check("R6 run1 count", 32'(lg_n), 32'd4);
        check_unit("R10 run1 u0", 0, 32'h500, 32'h600, 1'b0, 1'b0);
        check_unit("R10 run1 u1", 1, 32'h502, 32'h602, 1'b1, 1'b0);
        rd(0, 3, v); check("R10 still enabled", v, 32'hA260);
        wr(0, 0, 32'h900);
        wr(0, 3, 32'h0000_A260);
        repeat (8) @(negedge clk);
        check("R5 no restart", 32'(lg_n), 32'd4);
        clear_log();
        pulse(1'b1);
        wait_log(4);
        check("R10 run2 count", 32'(lg_n), 32'd4);
        check_unit("R5 R10 run2 u0", 0, 32'h504, 32'h600, 1'b0, 1'b0);
        check_unit("R10 run2 u1",    1, 32'h506, 32'h602, 1'b1, 1'b0);
        check("R11 no irq", 32'(irq_n[0]), 32'd0);
        wr(0, 3, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) irq_n[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_count();
        t_imm16_stall();
        t_wide_fixed();
        t_priority();
        t_repeat_reload();
        finish_run();
    end

endmodule